// File: doc/BRIEF.md
# UART Interrupt Identification and Prioritisation

This block sits beside a UART's receive and transmit datapaths and turns their status conditions into one interrupt request plus a read-only identification byte. Four sources feed it: receiver line errors (overrun, parity, framing, break), receive data available, character timeout and transmit holding register empty. Software enables each source through a small enable register. The identification byte reports the single highest-priority enabled source as a 3-bit code, with an active-low pending flag in bit 0.

A host read of the identification byte is a level strobe `iir_rd` that may last one or more cycles. A two-state machine follows each access. In `RD_IDLE`, the identification register reloads every cycle. A high `iir_rd` moves it to `RD_HOLD`, where the register is frozen. When `iir_rd` drops, it returns to `RD_IDLE`, and on that transition it clears the transmit-empty source if that was the reported code. Source events that arrive during `RD_HOLD` are still latched, so they show up in the first value loaded after the access.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, the enable readback is 0x00, the identification byte is 0x01 and `irq` is 0.
- R2: An enable write stores `ier_wdata[2:0]`. Bit 0 enables receive data and character timeout, bit 1 enables transmit empty, and bit 2 enables line status. Bits 7:3 of a write are ignored and read back as 0.
- R3: When an enabled source is pending, identification bits 3:1 show 011 for line status, else 010 for receive data, else 110 for character timeout, else 001 for transmit empty. A source whose enable bit is 0 is never reported.
- R4: Identification bit 0 is 0 exactly when an enabled source is pending. With nothing pending, bits 3:0 read 0001. Codes 000, 100, 101 and 111 never appear while bit 0 is 0.
- R5: Identification bits 7:6 both equal `fifo_en`, and bits 5:4 read 0.
- R6: `irq` is the inverse of identification bit 0. Outside a read, a change on a source, strobe or enable input appears in the identification byte and on `irq` one clock later.
- R7: While `iir_rd` is high, the identification byte does not change.
- R8: A source event that arrives while `iir_rd` is high, including on the cycle the read starts, is latched. It is reported in the value loaded one clock after `iir_rd` falls.
- R9: When an identification read ends with transmit empty as the reported code, the transmit-empty source clears. A read that reports any other code leaves it set.
- R10: The transmit-empty source sets on a rising edge of `thr_empty`, clears on `thr_wr`, and sets again only on the next rising edge.
- R11: The line-status source latches any `line_err` bit and clears on `lsr_rd`. Character timeout latches `rx_timeout` and clears on `rbr_rd`. Receive data available follows the `rx_avail` level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| iir_rd | input | 1 | Identification read in progress (level) |
| lsr_rd | input | 1 | Line status register read strobe |
| rbr_rd | input | 1 | Receive buffer read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| line_err | input | 4 | Receiver error and break flags |
| rx_avail | input | 1 | Receive data available level |
| rx_timeout | input | 1 | Character timeout event pulse |
| thr_empty | input | 1 | Transmit holding register empty level |
| fifo_en | input | 1 | FIFO enable control bit |
| ier_rdata | output | 8 | Enable register read data |
| iir_rdata | output | 8 | Identification register read data |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest situation to reach is an event that lands while the identification byte is frozen, because the port gives no sign of it until the access ends. The stimulus raises a line error on the same falling edge that raises `iir_rd`, and holds the read for several cycles. It checks that the byte still shows no interrupt throughout, then drops the strobe and expects the line-status code. A second hard case is a read that reports line status while transmit empty is also pending. The stimulus sets both sources, performs the read, clears line status, and expects the transmit-empty code to remain.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [2:0] {
        ID_NONE    = 3'b000,
        ID_TXEMPTY = 3'b001,
        ID_RXDATA  = 3'b010,
        ID_LINE    = 3'b011,
        ID_TIMEOUT = 3'b110
    } irq_id_e;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_HOLD = 1'b1
    } rd_state_e;

    typedef struct packed {
        logic line;
        logic rxdata;
        logic timeout;
        logic txempty;
    } irq_src_t;

endpackage

// File: rtl/uart_irq_src.sv
module uart_irq_src
    import uart_irq_pkg::*;
#(
    parameter int ERR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] line_err,
    input  logic             rx_avail,
    input  logic             rx_timeout,
    input  logic             thr_empty,
    input  logic             lsr_rd,
    input  logic             rbr_rd,
    input  logic             thr_wr,
    input  logic             tx_clr_rd,
    output irq_src_t         src_next
);

    logic line_q, tmo_q, txe_q, empty_q;
    logic txe_set;

    always_comb begin
        txe_set          = thr_empty & ~empty_q;
        src_next.line    = (|line_err) | (line_q & ~lsr_rd);
        src_next.rxdata  = rx_avail;
        src_next.timeout = rx_timeout | (tmo_q & ~rbr_rd);
        src_next.txempty = txe_set | (txe_q & ~thr_wr & ~tx_clr_rd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q  <= 1'b0;
            tmo_q   <= 1'b0;
            txe_q   <= 1'b0;
            empty_q <= 1'b0;
        end else begin
            line_q  <= src_next.line;
            tmo_q   <= src_next.timeout;
            txe_q   <= src_next.txempty;
            empty_q <= thr_empty;
        end
    end

    // R11
    line_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !(|line_err)) |=> !line_q);

    // R10
    tx_write_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr && !(thr_empty && !empty_q)) |=> !txe_q);

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int EN_W = 3
) (
    input  irq_src_t        src,
    input  logic [EN_W-1:0] en,
    output irq_id_e         id,
    output logic            none
);

    always_comb begin
        none = 1'b0;
        if (src.line && en[2])
            id = ID_LINE;
        else if (src.rxdata && en[0])
            id = ID_RXDATA;
        else if (src.timeout && en[0])
            id = ID_TIMEOUT;
        else if (src.txempty && en[1])
            id = ID_TXEMPTY;
        else begin
            id   = ID_NONE;
            none = 1'b1;
        end
    end

endmodule

// File: rtl/uart_irq_rdfsm.sv
module uart_irq_rdfsm
    import uart_irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iir_rd,
    input  logic              fifo_en,
    input  irq_id_e           id,
    input  logic              none,
    output logic [DATA_W-1:0] iir_q,
    output logic              tx_clr_rd
);

    rd_state_e         state_q, state_d;
    logic [DATA_W-1:0] iir_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            iir_q   <= DATA_W'(1);
        end else begin
            state_q <= state_d;
            iir_q   <= iir_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        tx_clr_rd = 1'b0;
        unique case (state_q)
            RD_IDLE: if (iir_rd) state_d = RD_HOLD;
            RD_HOLD: if (!iir_rd) begin
                state_d   = RD_IDLE;
                tx_clr_rd = (iir_q[3:1] == ID_TXEMPTY) && !iir_q[0];
            end
        endcase
        if (iir_rd)
            iir_d = iir_q;
        else
            iir_d = {{2{fifo_en}}, {(DATA_W-6){1'b0}}, id, none};
    end

    // R7
    frozen_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iir_rd |=> $stable(iir_q));

    // R4
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !iir_q[0] |-> (iir_q[3:1] inside {3'b011, 3'b010, 3'b110, 3'b001}));

    // R5
    fifo_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !iir_rd |=> (iir_q[DATA_W-1:DATA_W-2] == {2{$past(fifo_en)}}));

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ERR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ier_wr,
    input  logic [DATA_W-1:0] ier_wdata,
    input  logic              iir_rd,
    input  logic              lsr_rd,
    input  logic              rbr_rd,
    input  logic              thr_wr,
    input  logic [ERR_W-1:0]  line_err,
    input  logic              rx_avail,
    input  logic              rx_timeout,
    input  logic              thr_empty,
    input  logic              fifo_en,
    output logic [DATA_W-1:0] ier_rdata,
    output logic [DATA_W-1:0] iir_rdata,
    output logic              irq
);

    localparam int EN_W = 3;

    logic [EN_W-1:0] ier_q, ier_next;
    irq_src_t        src_next;
    irq_id_e         id;
    logic            none;
    logic            tx_clr_rd;

    assign ier_next = ier_wr ? ier_wdata[EN_W-1:0] : ier_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ier_q <= '0;
        else        ier_q <= ier_next;
    end

    uart_irq_src #(.ERR_W(ERR_W)) u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_err   (line_err),
        .rx_avail   (rx_avail),
        .rx_timeout (rx_timeout),
        .thr_empty  (thr_empty),
        .lsr_rd     (lsr_rd),
        .rbr_rd     (rbr_rd),
        .thr_wr     (thr_wr),
        .tx_clr_rd  (tx_clr_rd),
        .src_next   (src_next)
    );

    uart_irq_prio #(.EN_W(EN_W)) u_prio (
        .src  (src_next),
        .en   (ier_next),
        .id   (id),
        .none (none)
    );

    uart_irq_rdfsm #(.DATA_W(DATA_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .iir_rd    (iir_rd),
        .fifo_en   (fifo_en),
        .id        (id),
        .none      (none),
        .iir_q     (iir_rdata),
        .tx_clr_rd (tx_clr_rd)
    );

    assign ier_rdata = {{(DATA_W-EN_W){1'b0}}, ier_q};
    assign irq       = ~iir_rdata[0];

    // R2
    ier_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_wr && (|ier_wdata[DATA_W-1:EN_W])) |=> (ier_rdata[DATA_W-1:EN_W] == '0));

    // R3
    line_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!iir_rd && src_next.line && ier_next[2]) |=> (iir_rdata[3:0] == 4'b0110));

endmodule

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ier_wr = 0, iir_rd = 0, lsr_rd = 0, rbr_rd = 0, thr_wr = 0;
    logic [7:0] ier_wdata = '0;
    logic [3:0] line_err = '0;
    logic       rx_avail = 0, rx_timeout = 0, thr_empty = 0, fifo_en = 0;
    logic [7:0] ier_rdata, iir_rdata;
    logic       irq;
    int         n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    uart_irq_ident dut (
        .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
        .iir_rd(iir_rd), .lsr_rd(lsr_rd), .rbr_rd(rbr_rd), .thr_wr(thr_wr),
        .line_err(line_err), .rx_avail(rx_avail), .rx_timeout(rx_timeout),
        .thr_empty(thr_empty), .fifo_en(fifo_en),
        .ier_rdata(ier_rdata), .iir_rdata(iir_rdata), .irq(irq)
    );

    // {enable[2:0], line, rxdata, timeout, txempty, expected iir[3:0]}
    localparam int NV = 23;
    localparam logic [10:0] VEC [NV] = '{
        {3'd7, 4'b0000, 4'b0001}, {3'd7, 4'b0001, 4'b0010},
        {3'd7, 4'b0010, 4'b1100}, {3'd7, 4'b0011, 4'b1100},
        {3'd7, 4'b0100, 4'b0100}, {3'd7, 4'b0101, 4'b0100},
        {3'd7, 4'b0110, 4'b0100}, {3'd7, 4'b0111, 4'b0100},
        {3'd7, 4'b1000, 4'b0110}, {3'd7, 4'b1001, 4'b0110},
        {3'd7, 4'b1010, 4'b0110}, {3'd7, 4'b1011, 4'b0110},
        {3'd7, 4'b1100, 4'b0110}, {3'd7, 4'b1101, 4'b0110},
        {3'd7, 4'b1110, 4'b0110}, {3'd7, 4'b1111, 4'b0110},
        {3'd0, 4'b1111, 4'b0001}, {3'd1, 4'b1111, 4'b0100},
        {3'd2, 4'b1111, 4'b0010}, {3'd4, 4'b1111, 4'b0110},
        {3'd1, 4'b0010, 4'b1100}, {3'd6, 4'b0110, 4'b0001},
        {3'd3, 4'b1001, 4'b0010}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr_ier(input logic [7:0] v);
        ier_wr = 1; ier_wdata = v; tick(); ier_wr = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R1 reset state
        chk("R1 ier", ier_rdata, 8'h00);
        chk("R1 iir", iir_rdata, 8'h01);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;
        tick();

        // R3 R4 R6 priority table
        for (int i = 0; i < NV; i++) begin
            ier_wr = 1; ier_wdata = {5'd0, VEC[i][10:8]};
            line_err = VEC[i][7] ? 4'b0010 : 4'b0000;
            rx_avail = VEC[i][6]; rx_timeout = VEC[i][5]; thr_empty = VEC[i][4];
            tick();
            ier_wr = 0; line_err = '0; rx_timeout = 0;
            chk($sformatf("R3 vec %0d", i), {4'd0, iir_rdata[3:0]}, {4'd0, VEC[i][3:0]});
            chk($sformatf("R6 vec %0d", i), {7'd0, irq}, {7'd0, ~VEC[i][0]});
            lsr_rd = 1; rbr_rd = 1; thr_wr = 1; rx_avail = 0; thr_empty = 0;
            tick();
            lsr_rd = 0; rbr_rd = 0; thr_wr = 0;
            chk($sformatf("R4 idle after vec %0d", i), iir_rdata, 8'h01);
        end

        // R2 reserved enable bits
        wr_ier(8'hFF);
        chk("R2 reserved ignored", ier_rdata, 8'h07);
        wr_ier(8'h00);

        // R5 fifo bits
        fifo_en = 1; tick();
        chk("R5 fifo set", iir_rdata, 8'hC1);
        fifo_en = 0; tick();
        chk("R5 fifo clear", iir_rdata, 8'h01);

        // R6 one-clock latency, R11 rxdata level
        wr_ier(8'h01);
        rx_avail = 1; #1;
        chk("R6 before edge", {7'd0, irq}, 8'h00);
        tick();
        chk("R6 after edge", {7'd0, irq}, 8'h01);
        chk("R11 rxdata code", iir_rdata, 8'h04);
        rx_avail = 0; tick();
        chk("R11 rxdata level drop", iir_rdata, 8'h01);

        // R11 timeout sticky and cleared by rbr_rd
        rx_timeout = 1; tick(); rx_timeout = 0;
        chk("R11 timeout set", iir_rdata, 8'h0C);
        tick(); tick();
        chk("R11 timeout sticky", iir_rdata, 8'h0C);
        rbr_rd = 1; tick(); rbr_rd = 0;
        chk("R11 timeout clear", iir_rdata, 8'h01);

        // R11 line status cleared by lsr_rd
        wr_ier(8'h04);
        line_err = 4'b1000; tick(); line_err = '0;
        chk("R11 line set", iir_rdata, 8'h06);
        tick();
        chk("R11 line sticky", iir_rdata, 8'h06);
        lsr_rd = 1; tick(); lsr_rd = 0;
        chk("R11 line clear", iir_rdata, 8'h01);

        // R9 transmit empty cleared by read that reports it
        wr_ier(8'h02);
        thr_empty = 1; tick();
        chk("R10 txempty set", iir_rdata, 8'h02);
        iir_rd = 1; tick(); iir_rd = 0;
        chk("R7 frozen single read", iir_rdata, 8'h02);
        tick();
        chk("R9 cleared by read", iir_rdata, 8'h01);
        tick();
        chk("R10 no rearm while empty", iir_rdata, 8'h01);

        // R10 rearm on next rising edge, clear by write
        thr_empty = 0; tick();
        thr_empty = 1; tick();
        chk("R10 rearm", iir_rdata, 8'h02);
        thr_wr = 1; tick(); thr_wr = 0;
        chk("R10 write clear", iir_rdata, 8'h01);

        // R9 read reporting line status leaves txempty set
        thr_empty = 0; wr_ier(8'h06);
        thr_empty = 1; line_err = 4'b0001; tick(); line_err = '0;
        chk("R9 line over txempty", iir_rdata, 8'h06);
        iir_rd = 1; tick(); iir_rd = 0; tick();
        chk("R9 line still after read", iir_rdata, 8'h06);
        lsr_rd = 1; tick(); lsr_rd = 0;
        chk("R9 txempty survived", iir_rdata, 8'h02);
        thr_wr = 1; tick(); thr_wr = 0;
        chk("R10 txempty write clear", iir_rdata, 8'h01);

        // R7 R8 event on the cycle a read starts
        wr_ier(8'h07);
        iir_rd = 1; line_err = 4'b0100; tick(); line_err = '0;
        chk("R7 frozen during read", iir_rdata, 8'h01);
        tick(); tick();
        chk("R7 still frozen", iir_rdata, 8'h01);
        chk("R7 irq low", {7'd0, irq}, 8'h00);
        iir_rd = 0; tick();
        chk("R8 deferred event", iir_rdata, 8'h06);
        lsr_rd = 1; tick(); lsr_rd = 0;
        chk("R8 cleanup", iir_rdata, 8'h01);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule